// File: doc/BRIEF.md
# Signed-Amount Saturating Barrel Shifter

This block shifts or rotates a 64-bit operand by a signed 7-bit amount and registers the result. The sign of the amount reverses the shift direction. A left operation given a negative amount shifts right by the magnitude. A right operation given a negative amount shifts left. Arithmetic forms fill with the sign bit when moving right. Logical forms fill with zeros. There are two saturating forms. When one of them ends up shifting left, a result that cannot be represented is clamped toward the sign of the operand it started from, and the overflow output is raised.

A width select picks 64-bit or 32-bit operation. In 32-bit mode only the low half of the source is used, and the result is sign-extended from bit 31 onto the full output bus. Results and the overflow flag appear one clock after the inputs are presented. The block is meant for the execute stage of a datapath that needs C-like shift semantics with no undefined cases at full-width shift counts.

Top module: `bsh_shifter`

## Requirements
- R1: While `rst_ni` is low, `res_o` and `ovf_o` are zero.
- R2: The result and overflow for inputs sampled at one rising clock edge appear on the outputs after that edge and stay there until the next edge.
- R3: Operations 0 (arithmetic left) and 1 (logical left) with a non-negative amount n shift left by n with zero fill. An amount at or beyond the selected width gives zero.
- R4: Operations 0, 1 and 4 with a negative amount -n shift right by n. Operations 0 and 4 fill with the sign and operation 1 fills with zeros. A magnitude of the full width gives all sign bits or zero.
- R5: Operations 2 (arithmetic right) and 3 (logical right) with a non-negative amount n shift right by n. Operation 2 fills with the sign and operation 3 fills with zeros. An amount at or beyond the width gives all sign bits or zero.
- R6: Operations 2 and 3 with a negative amount -n shift left by n with zero fill.
- R7: Operation 4 (saturating left) with a non-negative amount n returns the operand times 2^n when that fits the selected signed width, with `ovf_o` low. Otherwise it returns the largest positive value for a non-negative operand or the most negative value for a negative operand, with `ovf_o` high. A positive operand whose bits are all shifted out therefore saturates.
- R8: Operation 5 (saturating right) with a negative amount applies the R7 rule as a left shift by the magnitude. With a non-negative amount it is an arithmetic right shift with `ovf_o` low.
- R9: Operation 6 rotates left and operation 7 rotates right, both by the amount modulo the selected width. A negative amount reverses the direction, and a rotate by zero returns the source unchanged.
- R10: With `w64_i` low only `src_i[31:0]` is used, and `res_o[63:32]` are copies of `res_o[31]`.
- R11: `ovf_o` is high only after a saturating operation (4 or 5) that actually shifted left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code, encodings as in R3 to R9 |
| w64_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| amt_i | input | 7 | Two's-complement shift amount |
| src_i | input | 64 | Source operand |
| res_o | output | 64 | Registered result |
| ovf_o | output | 1 | Registered saturation flag |

## Verification
The clocked checks assume the inputs are stable around the sampling edge, because each one compares the registered outputs with the inputs seen one edge earlier. They also assume a fresh sample exists only once reset has been high for an edge, so every check that looks back is gated by the reset value from the previous cycle. The bench changes inputs only on falling edges and reads outputs one falling edge after the rising edge that captured them, so it stays within both assumptions. Its vectors cover both fills, both widths, the ±64 magnitude extremes and exact-fit and one-past-fit saturation boundaries.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

   typedef enum logic [2:0] {
      OP_ASL  = 3'd0,
      OP_LSL  = 3'd1,
      OP_ASR  = 3'd2,
      OP_LSR  = 3'd3,
      OP_SATL = 3'd4,
      OP_SATR = 3'd5,
      OP_ROL  = 3'd6,
      OP_ROR  = 3'd7
   } bsh_op_e;

   // Resolved control after the amount sign has been folded in
   typedef struct packed {
      logic left;   // effective direction is left
      logic arith;  // sign fill / sign-extended operand
      logic sat;    // saturating left shift path
      logic rot;    // rotate path
   } bsh_ctl_t;

endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
   import bsh_pkg::*;
#(
   parameter int AMT_W = 7,
   parameter int SH_W  = 6
) (
   input  bsh_op_e          op_i,
   input  logic [AMT_W-1:0] amt_i,
   output bsh_ctl_t         ctl_o,
   output logic [AMT_W-1:0] mag_o,
   output logic [SH_W-1:0]  rot_o
);

   logic neg;
   logic base_left;

   assign neg       = amt_i[AMT_W-1];
   assign base_left = (op_i == OP_ASL) || (op_i == OP_LSL) || (op_i == OP_SATL);

   // Magnitude is unsigned, so the most negative amount maps to the full width
   assign mag_o = neg ? (~amt_i + 1'b1) : amt_i;

   always_comb begin
      ctl_o.left  = base_left ^ neg;
      ctl_o.arith = (op_i == OP_ASL) || (op_i == OP_ASR) ||
                    (op_i == OP_SATL) || (op_i == OP_SATR);
      ctl_o.sat   = ((op_i == OP_SATL) && !neg) || ((op_i == OP_SATR) && neg);
      ctl_o.rot   = (op_i == OP_ROL) || (op_i == OP_ROR);
   end

   // Rotate right becomes rotate left by the negated amount, modulo the width
   assign rot_o = (op_i == OP_ROR) ? (~amt_i[SH_W-1:0] + 1'b1) : amt_i[SH_W-1:0];

endmodule

// File: rtl/bsh_shift.sv
module bsh_shift #(
   parameter int DATA_W = 64,
   parameter int AMT_W  = 7,
   parameter int SH_W   = 6
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic              wide_i,
   input  logic              arith_i,
   input  logic [AMT_W-1:0]  mag_i,
   input  logic [SH_W-1:0]   rot_i,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o,
   output logic [DATA_W-1:0] rot_o
);

   localparam int HALF_W = DATA_W / 2;

   // Counts at or past the width give zero / all sign bits by language rule
   assign left_o  = x_i << mag_i;
   assign right_o = arith_i ? DATA_W'($signed(x_i) >>> mag_i) : (x_i >> mag_i);

   logic [DATA_W-1:0] rot_wide;
   logic [HALF_W-1:0] rot_narrow;

   // Complementary shift of (width - r); a zero count leaves the source intact
   assign rot_wide = (x_i << rot_i) | (x_i >> (DATA_W - int'(rot_i)));

   generate
      if (HALF_W > 1) begin : g_narrow_rot
         logic [HALF_W-1:0] y;
         logic [SH_W-2:0]   r_n;
         assign y          = x_i[HALF_W-1:0];
         assign r_n        = rot_i[SH_W-2:0];
         assign rot_narrow = (y << r_n) | (y >> (HALF_W - int'(r_n)));
      end else begin : g_no_narrow_rot
         assign rot_narrow = x_i[HALF_W-1:0];
      end
   endgenerate

   assign rot_o = wide_i ? rot_wide : {{HALF_W{1'b0}}, rot_narrow};

endmodule

// File: rtl/bsh_sat.sv
module bsh_sat #(
   parameter int DATA_W = 64,
   parameter int AMT_W  = 7
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic              wide_i,
   input  logic [AMT_W-1:0]  mag_i,
   output logic [DATA_W-1:0] res_o,
   output logic              ovf_o
);

   localparam int EXT_W  = 2 * DATA_W;
   localparam int HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] MAX_W = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MIN_W = ~MAX_W;
   localparam logic [DATA_W-1:0] MAX_N = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MIN_N = ~MAX_N;

   logic signed [EXT_W-1:0] xe;
   logic signed [EXT_W-1:0] prod;
   logic                    fits_w;
   logic                    fits_n;
   logic                    fits;
   logic [DATA_W-1:0]       clamp;

   // Exact product kept at double width, so no bit is lost before the fit test
   assign xe   = EXT_W'($signed(x_i));
   assign prod = xe <<< mag_i;

   assign fits_w = (prod == EXT_W'($signed(prod[DATA_W-1:0])));
   assign fits_n = (prod == EXT_W'($signed(prod[HALF_W-1:0])));
   assign fits   = wide_i ? fits_w : fits_n;

   // Clamp direction follows the operand before shifting, not the product
   always_comb begin
      if (wide_i) clamp = x_i[DATA_W-1] ? MIN_W : MAX_W;
      else        clamp = x_i[DATA_W-1] ? MIN_N : MAX_N;
   end

   assign res_o = fits ? prod[DATA_W-1:0] : clamp;
   assign ovf_o = !fits;

endmodule

// File: rtl/bsh_shifter.sv
module bsh_shifter
   import bsh_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int AMT_W  = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        op_i,
   input  logic              w64_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] res_o,
   output logic              ovf_o
);

   localparam int HALF_W = DATA_W / 2;
   localparam int SH_W   = $clog2(DATA_W);

   generate
      if ((DATA_W < 8) || ((1 << SH_W) != DATA_W)) begin : g_bad_width
         $error("bsh_shifter: DATA_W must be a power of two of at least 8");
      end
      if (AMT_W != SH_W + 1) begin : g_bad_amt
         $error("bsh_shifter: AMT_W must equal log2(DATA_W) + 1");
      end
   endgenerate

   bsh_op_e           op;
   bsh_ctl_t          ctl;
   logic [AMT_W-1:0]  mag;
   logic [SH_W-1:0]   rot_amt;
   logic [DATA_W-1:0] x;
   logic [DATA_W-1:0] sh_left;
   logic [DATA_W-1:0] sh_right;
   logic [DATA_W-1:0] sh_rot;
   logic [DATA_W-1:0] sat_res;
   logic              sat_ovf;
   logic [DATA_W-1:0] res_pre;
   logic [DATA_W-1:0] res_d;
   logic              ovf_d;

   assign op = bsh_op_e'(op_i);

   bsh_decode #(.AMT_W(AMT_W), .SH_W(SH_W)) u_decode (
      .op_i  (op),
      .amt_i (amt_i),
      .ctl_o (ctl),
      .mag_o (mag),
      .rot_o (rot_amt)
   );

   // Narrow mode: widen the low half by sign or zero according to the fill
   always_comb begin
      if (w64_i)          x = src_i;
      else if (ctl.arith) x = {{HALF_W{src_i[HALF_W-1]}}, src_i[HALF_W-1:0]};
      else                x = {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
   end

   bsh_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W), .SH_W(SH_W)) u_shift (
      .x_i     (x),
      .wide_i  (w64_i),
      .arith_i (ctl.arith),
      .mag_i   (mag),
      .rot_i   (rot_amt),
      .left_o  (sh_left),
      .right_o (sh_right),
      .rot_o   (sh_rot)
   );

   bsh_sat #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_sat (
      .x_i    (x),
      .wide_i (w64_i),
      .mag_i  (mag),
      .res_o  (sat_res),
      .ovf_o  (sat_ovf)
   );

   always_comb begin
      if (ctl.rot)       res_pre = sh_rot;
      else if (ctl.sat)  res_pre = sat_res;
      else if (ctl.left) res_pre = sh_left;
      else               res_pre = sh_right;
   end

   assign res_d = w64_i ? res_pre : {{HALF_W{res_pre[HALF_W-1]}}, res_pre[HALF_W-1:0]};
   assign ovf_d = ctl.sat & sat_ovf;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_o <= '0;
         ovf_o <= 1'b0;
      end else begin
         res_o <= res_d;
         ovf_o <= ovf_d;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |=> (rst_ni || (res_o == '0 && !ovf_o))); // R1

   AST_NARROW_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(rst_ni) && !$past(w64_i)) |-> (res_o[DATA_W-1:HALF_W] == {HALF_W{res_o[HALF_W-1]}})); // R10

   AST_OVF_SAT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o |-> ($past(op_i) == OP_SATL || $past(op_i) == OP_SATR)); // R11

   AST_OVF_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o |-> (res_o == {1'b0, {(DATA_W-1){1'b1}}} || res_o == {1'b1, {(DATA_W-1){1'b0}}} || res_o == {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}} || res_o == {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}})); // R7

   AST_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(rst_ni) && $past(src_i) == '0) |-> (res_o == '0 && !ovf_o)); // R11

   AST_ROT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(rst_ni) && $past(w64_i) && ($past(op_i) == OP_ROL || $past(op_i) == OP_ROR) && $past(amt_i[SH_W-1:0]) == '0) |-> (res_o == $past(src_i))); // R9

endmodule

// File: tb/bsh_shifter_test.sv
module bsh_shifter_test;

   typedef struct packed {
      logic [2:0]  op;
      logic        w64;
      logic [6:0]  amt;
      logic [63:0] src;
      logic [63:0] exp;
      logic        ovf;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 1'b1, 7'd4,   64'h0000_0000_0000_00F1, 64'h0000_0000_0000_0F10, 1'b0, 4'd3},  // R3
      '{3'd0, 1'b1, 7'd63,  64'h0000_0000_0000_0003, 64'h8000_0000_0000_0000, 1'b0, 4'd3},  // R3
      '{3'd0, 1'b0, 7'd32,  64'h0000_0000_0000_1234, 64'h0000_0000_0000_0000, 1'b0, 4'd3},  // R3 at width
      '{3'd0, 1'b1, 7'h7C,  64'h8000_0000_0000_0000, 64'hF800_0000_0000_0000, 1'b0, 4'd4},  // R4 -4
      '{3'd1, 1'b1, 7'h7C,  64'h8000_0000_0000_0000, 64'h0800_0000_0000_0000, 1'b0, 4'd4},  // R4 -4
      '{3'd0, 1'b1, 7'h40,  64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd4},  // R4 -64
      '{3'd1, 1'b1, 7'h40,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0, 4'd4},  // R4 -64
      '{3'd4, 1'b0, 7'h7C,  64'h0000_0000_8000_0000, 64'hFFFF_FFFF_F800_0000, 1'b0, 4'd4},  // R4 sat op, -4
      '{3'd2, 1'b1, 7'd8,   64'hF000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0, 4'd5},  // R5
      '{3'd3, 1'b1, 7'd8,   64'hF000_0000_0000_0000, 64'h00F0_0000_0000_0000, 1'b0, 4'd5},  // R5
      '{3'd3, 1'b0, 7'd40,  64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0, 4'd5},  // R5 past width
      '{3'd2, 1'b0, 7'd40,  64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd5},  // R5 past width
      '{3'd2, 1'b1, 7'h7D,  64'h0000_0000_0000_0011, 64'h0000_0000_0000_0088, 1'b0, 4'd6},  // R6 -3
      '{3'd3, 1'b1, 7'h44,  64'h0000_0000_0000_001F, 64'hF000_0000_0000_0000, 1'b0, 4'd6},  // R6 -60
      '{3'd4, 1'b0, 7'd4,   64'h0000_0000_0123_4567, 64'h0000_0000_1234_5670, 1'b0, 4'd7},  // R7 fits
      '{3'd4, 1'b0, 7'd8,   64'h0000_0000_0123_4567, 64'h0000_0000_7FFF_FFFF, 1'b1, 4'd7},  // R7 clamp max
      '{3'd4, 1'b0, 7'd4,   64'hFFFF_FFFF_F800_0000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd7},  // R7 exact min
      '{3'd4, 1'b0, 7'd5,   64'hFFFF_FFFF_F800_0000, 64'hFFFF_FFFF_8000_0000, 1'b1, 4'd7},  // R7 one past
      '{3'd4, 1'b0, 7'd32,  64'h0000_0000_0000_0001, 64'h0000_0000_7FFF_FFFF, 1'b1, 4'd7},  // R7 shifted out
      '{3'd4, 1'b1, 7'd1,   64'h4000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'd7},  // R7 wide
      '{3'd4, 1'b1, 7'd63,  64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, 4'd7},  // R7 wide fits
      '{3'd5, 1'b0, 7'h78,  64'h0000_0000_0123_4567, 64'h0000_0000_7FFF_FFFF, 1'b1, 4'd8},  // R8 -8
      '{3'd5, 1'b0, 7'd8,   64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FF80_0000, 1'b0, 4'd8},  // R8 right
      '{3'd5, 1'b1, 7'h7E,  64'hE000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 4'd8},  // R8 -2 fits
      '{3'd6, 1'b1, 7'd4,   64'hF000_0000_0000_0001, 64'h0000_0000_0000_001F, 1'b0, 4'd9},  // R9
      '{3'd7, 1'b1, 7'd4,   64'hF000_0000_0000_0001, 64'h1F00_0000_0000_0000, 1'b0, 4'd9},  // R9
      '{3'd6, 1'b1, 7'h7C,  64'hF000_0000_0000_0001, 64'h1F00_0000_0000_0000, 1'b0, 4'd9},  // R9 -4
      '{3'd6, 1'b1, 7'd0,   64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 4'd9},  // R9 zero
      '{3'd7, 1'b0, 7'd8,   64'hAAAA_AAAA_1234_5678, 64'h0000_0000_7812_3456, 1'b0, 4'd9},  // R9 narrow
      '{3'd6, 1'b0, 7'd36,  64'h0000_0000_1234_5678, 64'h0000_0000_2345_6781, 1'b0, 4'd9},  // R9 modulo
      '{3'd1, 1'b0, 7'd4,   64'hDEAD_BEEF_0800_0000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd10}, // R10
      '{3'd3, 1'b0, 7'd0,   64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd10}, // R10
      '{3'd0, 1'b1, 7'd8,   64'h7F00_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 4'd11}  // R11 no flag
   };

   logic        clk;
   logic        rst_n;
   logic [2:0]  op;
   logic        w64;
   logic [6:0]  amt;
   logic [63:0] src;
   logic [63:0] res;
   logic        ovf;
   int          n_checks;
   int          n_errors;

   bsh_shifter uut (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .op_i   (op),
      .w64_i  (w64),
      .amt_i  (amt),
      .src_i  (src),
      .res_o  (res),
      .ovf_o  (ovf)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op  = v.op;
      w64 = v.w64;
      amt = v.amt;
      src = v.src;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      n_checks = 0;
      n_errors = 0;
      rst_n = 1'b0;
      drive(VEC[1]);
      repeat (3) @(negedge clk);
      // R1: outputs held at zero during reset despite active inputs
      check("R1 res", res, 64'h0);
      check("R1 ovf", {63'h0, ovf}, 64'h0);
      rst_n = 1'b1;

      // Vector table
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(negedge clk);
         check($sformatf("R%0d res vec %0d", VEC[i].req, i), res, VEC[i].exp);
         check($sformatf("R%0d ovf vec %0d", VEC[i].req, i), {63'h0, ovf}, {63'h0, VEC[i].ovf});
      end

      // R2: output holds its value until the next rising edge
      drive(VEC[15]);
      @(negedge clk);
      check("R2 before", res, 64'h0000_0000_7FFF_FFFF);
      drive(VEC[0]);
      #3;
      check("R2 hold res", res, 64'h0000_0000_7FFF_FFFF);
      check("R2 hold ovf", {63'h0, ovf}, 64'h1);
      @(negedge clk);
      check("R2 after res", res, 64'h0000_0000_0000_0F10);
      check("R2 after ovf", {63'h0, ovf}, 64'h0);

      // R10: upper source half ignored in 32-bit mode
      drive('{3'd1, 1'b0, 7'd0, 64'hFFFF_0000_0000_0042, 64'h0, 1'b0, 4'd10});
      @(negedge clk);
      check("R10 upper ignored", res, 64'h0000_0000_0000_0042);

      // R11: a saturating right op with a positive amount never flags
      drive('{3'd5, 1'b1, 7'd1, 64'h8000_0000_0000_0000, 64'h0, 1'b0, 4'd11});
      @(negedge clk);
      check("R11 res", res, 64'hC000_0000_0000_0000);
      check("R11 ovf", {63'h0, ovf}, 64'h0);

      // R1: asynchronous reset mid-run clears outputs at once
      drive(VEC[19]);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1 async res", res, 64'h0);
      check("R1 async ovf", {63'h0, ovf}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 after reset", res, 64'h7FFF_FFFF_FFFF_FFFF);

      finish_run();
   end

endmodule